// File: doc/BRIEF.md
# NVM command handshake controller

This block is the software-facing front end of a non-volatile memory engine. It holds a command word and a status word on a small register port. Software writes the command word with a start bit and four operation flags: write-not-read, erase, first-of-burst and last-of-burst. The block then launches one operation toward a protocol backend and holds the flags steady for the backend while the operation runs. When the backend reports completion, the block raises a completion flag. That flag is also the attention output. The backend itself sits outside this block, behind the start/complete handshake.

The command word has two more self-clearing controls. A soft reset puts the whole engine back to idle. A bus-reset request for a serial EEPROM drives exactly nine dummy clock pulses on a serial clock pin and then raises its own done indication. The command word also reports a four-bit policy-error field supplied from outside. The status word shows the state codes of two backend state machines.

Top module: `nvm_cmd_top`

## Requirements
- R1: After reset, the command word (address 0) and the status word (address 1) read as zero, apart from the externally fed fields. The outputs beStart, engineReset, attn and serClk are low.
- R2: Writing the command word with bit 4 (start) set while the block is idle with completion clear starts an operation. beStart is high for exactly the one cycle after the accepting edge. Bit 4 reads 1 and bit 3 (completion) reads 0 for as long as the operation is in flight.
- R3: A beComplete pulse during an operation ends it. Bit 4 reads 0 and bit 3 reads 1 from the next cycle, and attn always equals bit 3.
- R4: Writing a 1 to bit 3 clears completion and attn. Writing 0 to bit 3 leaves it unchanged.
- R5: A start request is ignored while completion is set, while an operation is in flight, or while an EEPROM reset sequence runs. It raises no beStart and leaves completion unchanged.
- R6: The backend sees beWrite equal to bit 5 and beErase equal to bit 5 AND bit 6. An erase flag without the write flag is ignored.
- R7: Bits 7 (first) and 8 (last) reach beFirst and beLast unchanged. All four backend flag outputs keep the values captured at launch until the next launch, even if the command word is rewritten. The rewritten bits 8:5 read back as written.
- R8: Writing a 1 to bit 0 raises engineReset and bit 0 for exactly one cycle. It clears start, completion and any EEPROM sequence. If start is set in the same write, the reset wins and no operation starts.
- R9: Writing a 1 to bit 17 while idle starts the EEPROM reset sequence and clears bit 16. serClk then gives exactly 9 high pulses, each phase 2 cycles long. The sequence takes 36 cycles after the accepting edge, with bit 17 reading 1 throughout. Bit 16 then reads 1. The request is ignored while an operation is in flight.
- R10: Command bits 31:28 show policyErr. Status bits 7:4 show eepFsmState and bits 3:0 show spiFsmState. Reserved bits read 0, and writes to the status word change nothing.
- R11: A beComplete pulse while no operation is in flight has no effect on completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Word address for read and write (0 command, 1 status) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| policyErr | input | 4 | Address-lockout policy error code |
| eepFsmState | input | 4 | EEPROM backend state code |
| spiFsmState | input | 4 | Flash backend state code |
| beStart | output | 1 | One-cycle launch pulse to the backend |
| beWrite | output | 1 | Operation is a write or erase |
| beErase | output | 1 | Operation is an erase |
| beFirst | output | 1 | First command of a burst |
| beLast | output | 1 | Last command of a burst; backend flushes its buffer |
| beComplete | input | 1 | Backend completion pulse |
| engineReset | output | 1 | One-cycle soft reset of the engine |
| attn | output | 1 | Attention, equal to the completion flag |
| serClk | output | 1 | Serial EEPROM clock carrying the dummy pulses |

## Verification
A controller stuck in the in-flight state shows up in the first completion check. Bit 4 stays 1, attn never rises, and every later start request is silently dropped. A lost or duplicated launch shows as a missing or two-cycle beStart, one cycle after the accepting edge. A miscounted dummy-clock sequence shows as a wrong pulse count or a wrong cycle on which bit 16 rises. The sweep over all sixteen flag combinations exposes a swapped or stale backend flag on the launch cycle itself.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

  // Command word bit positions (software decodes these)
  localparam int BitSoftRst  = 0;
  localparam int BitDone     = 3;
  localparam int BitStart    = 4;
  localparam int FlagLsb     = 5;   // bits 8:5 hold {last, first, erase, wr}
  localparam int BitEepDone  = 16;
  localparam int BitEepGo    = 17;
  localparam int PolicyLsb   = 28;

  // Flag group as it sits in bits 8:5
  typedef struct packed {
    logic last;
    logic first;
    logic erase;
    logic wr;
  } cmdFlags_t;

  // Decoded command-word write
  typedef struct packed {
    logic softRst;
    logic doneClr;
    logic start;
    logic eepGo;
  } wrReq_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic launch;
    logic eepGo;
    logic abort;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    StIdle = 2'd0,
    StCmd  = 2'd1,
    StEep  = 2'd2
  } ctlState_t;

endpackage

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
  import nvm_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrite,
  input  wrReq_t      wrReq,
  input  logic        beComplete,
  input  logic        eepFinished,
  output ctrlStrobe_t strobe,
  output logic        cmdActive,
  output logic        eepRunning,
  output logic        doneFlag,
  output logic        eepDoneFlag,
  output logic        engineReset
);

  ctlState_t state;
  logic wantReset, wantStart, wantEep;

  assign wantReset = cmdWrite && wrReq.softRst;
  assign wantStart = cmdWrite && wrReq.start && !wantReset
                     && (state == StIdle) && !doneFlag;
  assign wantEep   = cmdWrite && wrReq.eepGo && !wantReset && !wantStart
                     && (state == StIdle);

  assign strobe.launch = wantStart;
  assign strobe.eepGo  = wantEep;
  assign strobe.abort  = wantReset;

  assign cmdActive  = (state == StCmd);
  assign eepRunning = (state == StEep);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= StIdle;
      doneFlag    <= 1'b0;
      eepDoneFlag <= 1'b0;
      engineReset <= 1'b0;
    end else begin
      engineReset <= wantReset;
      if (wantReset) begin
        state       <= StIdle;
        doneFlag    <= 1'b0;
        eepDoneFlag <= 1'b0;
      end else begin
        if (cmdWrite && wrReq.doneClr) doneFlag <= 1'b0;
        unique case (state)
          StIdle: begin
            if (wantStart) begin
              state    <= StCmd;
              doneFlag <= 1'b0;
            end else if (wantEep) begin
              state       <= StEep;
              eepDoneFlag <= 1'b0;
            end
          end
          StCmd: begin
            if (beComplete) begin
              state    <= StIdle;
              doneFlag <= 1'b1;
            end
          end
          StEep: begin
            if (eepFinished) begin
              state       <= StIdle;
              eepDoneFlag <= 1'b1;
            end
          end
          default: state <= StIdle;
        endcase
      end
    end
  end

  // R3
  complete_sets_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdActive && beComplete && !wantReset) |=> (doneFlag && !cmdActive));

  // R5
  no_active_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdActive && doneFlag));

  // R8
  soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    wantReset |=> (engineReset && !cmdActive && !eepRunning && !doneFlag));

endmodule

// File: rtl/nvm_cmd_dpath.sv
module nvm_cmd_dpath
  import nvm_cmd_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int CMD_ADDR   = 0,
  parameter int STAT_ADDR  = 1,
  parameter int DUMMY_CLKS = 9,
  parameter int HALF_PER   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  cmdFlags_t         wrFlags,
  input  logic [ADDR_W-1:0] regAddr,
  input  ctrlStrobe_t       strobe,
  input  logic              cmdActive,
  input  logic              eepRunning,
  input  logic              doneFlag,
  input  logic              eepDoneFlag,
  input  logic              engineReset,
  input  logic [3:0]        policyErr,
  input  logic [3:0]        eepFsmState,
  input  logic [3:0]        spiFsmState,
  output logic [31:0]       regRdData,
  output logic              beStart,
  output logic              beWrite,
  output logic              beErase,
  output logic              beFirst,
  output logic              beLast,
  output logic              serClk,
  output logic              eepFinished
);

  localparam int PH_W  = $clog2(HALF_PER) + 1;
  localparam int CNT_W = $clog2(DUMMY_CLKS) + 1;
  localparam logic [PH_W-1:0]  PhLast  = PH_W'(HALF_PER - 1);
  localparam logic [CNT_W-1:0] CntLast = CNT_W'(DUMMY_CLKS - 1);

  cmdFlags_t storedFlags, launchFlags;

  // Software-visible flag storage and launch capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedFlags <= '0;
      launchFlags <= '0;
      beStart     <= 1'b0;
    end else begin
      if (cmdWrite) storedFlags <= wrFlags;
      if (strobe.launch) launchFlags <= wrFlags;
      beStart <= strobe.launch;
    end
  end

  assign beWrite = launchFlags.wr;
  assign beErase = launchFlags.wr & launchFlags.erase;
  assign beFirst = launchFlags.first;
  assign beLast  = launchFlags.last;

  // Dummy serial clock generator
  logic             genOn;
  logic [PH_W-1:0]  phaseCnt;
  logic [CNT_W-1:0] pulseCnt;

  assign eepFinished = genOn && (phaseCnt == PhLast) && serClk
                       && (pulseCnt == CntLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genOn    <= 1'b0;
      phaseCnt <= '0;
      pulseCnt <= '0;
      serClk   <= 1'b0;
    end else if (strobe.abort) begin
      genOn    <= 1'b0;
      phaseCnt <= '0;
      pulseCnt <= '0;
      serClk   <= 1'b0;
    end else if (strobe.eepGo) begin
      genOn    <= 1'b1;
      phaseCnt <= '0;
      pulseCnt <= '0;
      serClk   <= 1'b0;
    end else if (genOn) begin
      if (phaseCnt == PhLast) begin
        phaseCnt <= '0;
        serClk   <= ~serClk;
        if (serClk) begin
          if (pulseCnt == CntLast) genOn <= 1'b0;
          else pulseCnt <= pulseCnt + 1'b1;
        end
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  // Read mux; reserved bits are zero
  logic [31:0] cmdWord, statWord;

  always_comb begin
    cmdWord = '0;
    cmdWord[BitSoftRst]            = engineReset;
    cmdWord[BitDone]               = doneFlag;
    cmdWord[BitStart]              = cmdActive;
    cmdWord[FlagLsb +: 4]          = storedFlags;
    cmdWord[BitEepDone]            = eepDoneFlag;
    cmdWord[BitEepGo]              = eepRunning;
    cmdWord[PolicyLsb +: 4]        = policyErr;
    statWord                       = {24'd0, eepFsmState, spiFsmState};
  end

  always_comb begin
    if (regAddr == ADDR_W'(CMD_ADDR))       regRdData = cmdWord;
    else if (regAddr == ADDR_W'(STAT_ADDR)) regRdData = statWord;
    else                                    regRdData = '0;
  end

  // R2
  launch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |=> beStart);

  // R2
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    beStart |=> !beStart);

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdActive && !strobe.launch) |=> $stable({beWrite, beErase, beFirst, beLast}));

  // R9
  serclk_in_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> eepRunning);

endmodule

// File: rtl/nvm_cmd_top.sv
module nvm_cmd_top
  import nvm_cmd_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int CMD_ADDR   = 0,
  parameter int STAT_ADDR  = 1,
  parameter int DUMMY_CLKS = 9,
  parameter int HALF_PER   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [3:0]        policyErr,
  input  logic [3:0]        eepFsmState,
  input  logic [3:0]        spiFsmState,
  output logic              beStart,
  output logic              beWrite,
  output logic              beErase,
  output logic              beFirst,
  output logic              beLast,
  input  logic              beComplete,
  output logic              engineReset,
  output logic              attn,
  output logic              serClk
);

  logic        cmdWrite;
  wrReq_t      wrReq;
  cmdFlags_t   wrFlags;
  ctrlStrobe_t strobe;
  logic        cmdActive, eepRunning, doneFlag, eepDoneFlag, eepFinished;

  assign cmdWrite      = regWrEn && (regAddr == ADDR_W'(CMD_ADDR));
  assign wrReq.softRst = regWrData[BitSoftRst];
  assign wrReq.doneClr = regWrData[BitDone];
  assign wrReq.start   = regWrData[BitStart];
  assign wrReq.eepGo   = regWrData[BitEepGo];
  assign wrFlags       = regWrData[FlagLsb +: 4];

  nvm_cmd_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdWrite    (cmdWrite),
    .wrReq       (wrReq),
    .beComplete  (beComplete),
    .eepFinished (eepFinished),
    .strobe      (strobe),
    .cmdActive   (cmdActive),
    .eepRunning  (eepRunning),
    .doneFlag    (doneFlag),
    .eepDoneFlag (eepDoneFlag),
    .engineReset (engineReset)
  );

  nvm_cmd_dpath #(
    .ADDR_W     (ADDR_W),
    .CMD_ADDR   (CMD_ADDR),
    .STAT_ADDR  (STAT_ADDR),
    .DUMMY_CLKS (DUMMY_CLKS),
    .HALF_PER   (HALF_PER)
  ) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .cmdWrite    (cmdWrite),
    .wrFlags     (wrFlags),
    .regAddr     (regAddr),
    .strobe      (strobe),
    .cmdActive   (cmdActive),
    .eepRunning  (eepRunning),
    .doneFlag    (doneFlag),
    .eepDoneFlag (eepDoneFlag),
    .engineReset (engineReset),
    .policyErr   (policyErr),
    .eepFsmState (eepFsmState),
    .spiFsmState (spiFsmState),
    .regRdData   (regRdData),
    .beStart     (beStart),
    .beWrite     (beWrite),
    .beErase     (beErase),
    .beFirst     (beFirst),
    .beLast      (beLast),
    .serClk      (serClk),
    .eepFinished (eepFinished)
  );

  assign attn = doneFlag;

  // R3
  attn_tracks_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beComplete && cmdActive && !(cmdWrite && wrReq.softRst)) |=> attn);

endmodule

// File: tb/sim_nvm_cmd_top.sv
module sim_nvm_cmd_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [3:0]  policyErr, eepFsmState, spiFsmState;
  logic        beStart, beWrite, beErase, beFirst, beLast, beComplete;
  logic        engineReset, attn, serClk;

  always #5 clk = ~clk;

  nvm_cmd_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .policyErr(policyErr),
    .eepFsmState(eepFsmState), .spiFsmState(spiFsmState),
    .beStart(beStart), .beWrite(beWrite), .beErase(beErase),
    .beFirst(beFirst), .beLast(beLast), .beComplete(beComplete),
    .engineReset(engineReset), .attn(attn), .serClk(serClk)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  localparam int SeqCycles = 2 * 2 * 9;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd0; regWrData = '0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
    regAddr = 2'd0;
  endtask

  task automatic pulseComplete();
    @(negedge clk);
    beComplete = 1'b1;
    @(negedge clk);
    beComplete = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish();
  end

  initial begin
    logic [31:0] rd;
    int n;
    int rises;
    logic prev;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    policyErr = '0; eepFsmState = '0; spiFsmState = '0; beComplete = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(0, rd); check("R1 cmd word", rd, 32'h0);
    rdReg(1, rd); check("R1 status word", rd, 32'h0);
    check("R1 outputs", {28'd0, beStart, engineReset, attn, serClk}, 32'h0);

    // R2 R3 R4 R5 R6 R7 sweep over all flag combinations
    for (int f = 0; f < 16; f++) begin
      logic [3:0] fl;
      fl = 4'(f);
      wrReg(0, (32'(fl) << 5) | 32'h10);
      check("R2 beStart launch", {31'd0, beStart}, 32'd1);
      check("R6 beWrite", {31'd0, beWrite}, {31'd0, fl[0]});
      check("R6 beErase", {31'd0, beErase}, {31'd0, fl[0] & fl[1]});
      check("R7 first/last", {30'd0, beLast, beFirst}, {30'd0, fl[3], fl[2]});
      rdReg(0, rd);
      check("R2 start=1 done=0", {30'd0, rd[4], rd[3]}, 32'd2);
      check("R7 flag readback", {28'd0, rd[8:5]}, {28'd0, fl});
      @(negedge clk);
      check("R2 beStart single cycle", {31'd0, beStart}, 32'd0);
      wrReg(0, 32'(~fl) << 5);
      check("R7 flags held", {28'd0, beLast, beFirst, beErase, beWrite},
            {28'd0, fl[3], fl[2], fl[0] & fl[1], fl[0]});
      rdReg(0, rd);
      check("R7 rewritten readback", {28'd0, rd[8:5]}, {28'd0, ~fl});
      wrReg(0, 32'h10);
      check("R5 start while active", {31'd0, beStart}, 32'd0);
      pulseComplete();
      rdReg(0, rd);
      check("R3 done set start clear", {30'd0, rd[4], rd[3]}, 32'd1);
      check("R3 attn", {31'd0, attn}, 32'd1);
      wrReg(0, 32'h10);
      rdReg(0, rd);
      check("R5 start while done", {29'd0, beStart, rd[4], rd[3]}, 32'd1);
      wrReg(0, 32'h0);
      rdReg(0, rd);
      check("R4 write zero keeps done", {31'd0, rd[3]}, 32'd1);
      wrReg(0, 32'h8);
      rdReg(0, rd);
      check("R4 done cleared", {30'd0, attn, rd[3]}, 32'd0);
    end

    // R11 stray completion while idle
    pulseComplete();
    rdReg(0, rd);
    check("R11 stray complete", {30'd0, attn, rd[3]}, 32'd0);

    // R10 external fields and reserved bits
    for (int v = 0; v < 16; v++) begin
      policyErr = 4'(v); eepFsmState = 4'(v); spiFsmState = 4'(15 - v);
      rdReg(0, rd); check("R10 policy field", rd, 32'(v) << 28);
      rdReg(1, rd); check("R10 status fields", rd, {24'd0, 4'(v), 4'(15 - v)});
    end
    wrReg(1, 32'hFFFF_FFFF);
    rdReg(1, rd); check("R10 status write ignored", rd, {24'd0, 8'hF0});
    rdReg(0, rd); check("R10 cmd after status write", rd, 32'hF000_0000);
    policyErr = '0; eepFsmState = '0; spiFsmState = '0;

    // R9 dummy clock sequence
    wrReg(0, 32'h2_0000);
    rdReg(0, rd);
    check("R9 running bit", {30'd0, rd[17], rd[16]}, 32'd2);
    n = 0; rises = 0; prev = serClk;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      n++;
      if (serClk && !prev) rises++;
      prev = serClk;
      rdReg(0, rd);
      if (rd[16]) break;
    end
    check("R9 sequence length", n, SeqCycles);
    check("R9 pulse count", rises, 9);
    check("R9 end state", {30'd0, rd[17], serClk}, 32'd0);

    // R5 start during EEPROM sequence; R9 done clears on new request
    wrReg(0, 32'h2_0000);
    rdReg(0, rd);
    check("R9 done cleared on restart", {31'd0, rd[16]}, 32'd0);
    wrReg(0, 32'h10);
    rdReg(0, rd);
    check("R5 start during eeprom seq", {30'd0, beStart, rd[4]}, 32'd0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rdReg(0, rd);
      if (rd[16]) break;
    end
    check("R9 second sequence done", {31'd0, rd[16]}, 32'd1);

    // R9 request ignored while a command runs
    wrReg(0, 32'h10);
    wrReg(0, 32'h2_0000);
    rdReg(0, rd);
    check("R9 ignored while active", {31'd0, rd[17]}, 32'd0);
    rises = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (serClk) rises++;
    end
    check("R9 no serClk while active", rises, 0);
    pulseComplete();
    wrReg(0, 32'h8);

    // R8 soft reset during a command
    wrReg(0, 32'h10);
    wrReg(0, 32'h1);
    rdReg(0, rd);
    check("R8 reset pulse", {28'd0, engineReset, rd[0], rd[4], rd[3]}, 32'hC);
    @(negedge clk);
    rdReg(0, rd);
    check("R8 reset self clears", {30'd0, engineReset, rd[0]}, 32'd0);
    pulseComplete();
    rdReg(0, rd);
    check("R11 complete after reset", {30'd0, attn, rd[3]}, 32'd0);

    // R8 reset beats start in the same write
    wrReg(0, 32'h11);
    rdReg(0, rd);
    check("R8 reset wins over start", {29'd0, engineReset, beStart, rd[4]}, 32'd4);

    // R8 reset aborts EEPROM sequence
    wrReg(0, 32'h2_0000);
    repeat (5) @(negedge clk);
    wrReg(0, 32'h1);
    rdReg(0, rd);
    check("R8 eeprom aborted", {30'd0, rd[17], rd[16]}, 32'd0);
    repeat (40) @(negedge clk);
    rdReg(0, rd);
    check("R8 eeprom stays idle", {29'd0, rd[17], rd[16], serClk}, 32'd0);

    finish();
  end

endmodule